// File: doc/BRIEF.md
# NCO Quadrature Up-Conversion Modulator

This block moves a complex baseband stream up to an intermediate frequency. Every clock it takes one signed 14-bit in-phase sample and one signed 14-bit quadrature sample. It mixes them with a cosine and sine carrier from an internal numerically controlled oscillator and emits one signed 14-bit real sample. The oscillator is a 32-bit phase accumulator that steps by a programmable frequency word. A 16-bit phase offset is added to its top bits, and the result addresses a quarter-wave sine table.

Software loads the frequency word and the phase offset one byte at a time through a small write port. The new values are only staged at first. A separate commit strobe moves all staged values into the oscillator in one cycle, so the oscillator never runs with a half-written word.

Three per-sample controls change the output:
- One selects the sideband by reversing the sign of the sine term.
- One selects a coarse low-power oscillator that uses only the top five bits of the frequency and phase settings.
- One applies a gain of 181/256 (about -3 dB), so that full-scale I and Q together do not clip.

Top module: `nco_upmix`

## Requirements
- R1: While `rst` is high and on the first cycles after it, `modOut` is 0. Reset sets the active and staged frequency word to 32'h2666_6666 and the active and staged phase offset to 0.
- R2: The 32-bit accumulator starts at 0 after reset and adds the active frequency increment at every clock edge, modulo 2^32. A sample captured at an edge uses the accumulator value held just before that edge.
- R3: A write with `regWrEn` high stores `regData` into a staged byte. Addresses 0, 1, 2 and 3 hold frequency bits 7:0, 15:8, 23:16 and 31:24. Addresses 4 and 5 hold phase bits 7:0 and 15:8. Staged bytes have no effect on `modOut` until an edge with `regCommit` high copies every staged value into the active registers, and the new values are used from the next edge on.
- R4: The lookup phase is (accumulator bits 31:16 + active phase offset) mod 2^16.
- R5: In normal mode the table address p is lookup-phase bits 15:6. It gives cos = round(8191·cos(2π(p+0.5)/1024)) and sin = round(8191·sin(2π(p+0.5)/1024)), built from a 256-entry quarter table by quadrant folding.
- R6: The mixed value is d = I·cos − Q·sin when `flipSideband` is 0, and d = I·cos + Q·sin when it is 1.
- R7: `modOut` = floor((d + 4096) / 8192), saturated to the range −8192..8191.
- R8: With `gainTrim` high, d is replaced by floor((d·181 + 128) / 256) before the rounding step of R7.
- R9: With `lowPower` high, three things change:
  - The accumulator step is the active frequency word with bits 26:0 cleared.
  - The phase offset is used with bits 10:0 cleared.
  - The table address is lookup-phase bits 15:11 followed by five zero bits.
- R10: A sample and its controls (`flipSideband`, `lowPower`, `gainTrim`) presented before a rising edge appear on `modOut` after the fourth rising edge, counting the capture edge as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sampleI | input | 14 | Signed in-phase baseband sample |
| sampleQ | input | 14 | Signed quadrature baseband sample |
| flipSideband | input | 1 | Selects the sign of the sine term |
| lowPower | input | 1 | Coarse 5-bit oscillator mode |
| gainTrim | input | 1 | Applies the 181/256 gain |
| regWrEn | input | 1 | Byte write enable for the staged registers |
| regAddr | input | 3 | Staged register byte address |
| regData | input | 8 | Byte to write |
| regCommit | input | 1 | Copies staged values into the active oscillator registers |
| modOut | output | 14 | Signed modulated output sample |

## Verification
Each sample and its controls come out on `modOut` four rising edges after the edge that captures them. A register write changes only staged state. A commit takes effect on the accumulator increment and phase offset from the edge after the commit edge.

The bench models the accumulator, the staged and active registers and the arithmetic in the order these timing rules give. The driver stamps each expected value with the cycle number four edges ahead. The monitor compares that value on the falling edge of exactly that cycle, so a late or early result is reported as a mismatch.

// File: rtl/nco_mod_pkg.sv
package nco_mod_pkg;
  localparam int ACC_W   = 32;
  localparam int PHOFS_W = 16;
  localparam int AMP_W   = 14;
  localparam int LUT_W   = 10;
  localparam int LP_W    = 5;
  localparam int BYTE_W  = 8;
  localparam int RADDR_W = 3;
  localparam logic [ACC_W-1:0] FREQ_AT_RESET = 32'h2666_6666;

  typedef struct packed {
    logic [ACC_W-1:0]   freqWord;
    logic [PHOFS_W-1:0] phaseOfs;
  } oscCfg_t;
endpackage

// File: rtl/nco_regs.sv
module nco_regs
  import nco_mod_pkg::*;
#(
  parameter int ADDR_BITS = RADDR_W,
  parameter int DATA_BITS = BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic [ADDR_BITS-1:0] wrAddr,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic                 commit,
  output oscCfg_t              cfg
);
  localparam int FREQ_BYTES  = ACC_W / DATA_BITS;
  localparam int PHASE_BYTES = PHOFS_W / DATA_BITS;

  logic [ACC_W-1:0]   stgFreq, actFreq;
  logic [PHOFS_W-1:0] stgPhase, actPhase;

  always_ff @(posedge clk) begin
    if (rst) begin
      stgFreq  <= FREQ_AT_RESET;
      actFreq  <= FREQ_AT_RESET;
      stgPhase <= '0;
      actPhase <= '0;
    end else begin
      if (commit) begin
        actFreq  <= stgFreq;
        actPhase <= stgPhase;
      end
      if (wrEn) begin
        for (int b = 0; b < FREQ_BYTES; b++)
          if (wrAddr == ADDR_BITS'(b)) stgFreq[b*DATA_BITS +: DATA_BITS] <= wrData;
        for (int b = 0; b < PHASE_BYTES; b++)
          if (wrAddr == ADDR_BITS'(FREQ_BYTES + b)) stgPhase[b*DATA_BITS +: DATA_BITS] <= wrData;
      end
    end
  end

  assign cfg = '{freqWord: actFreq, phaseOfs: actPhase};

  // R3: a commit moves the staged values over in one edge
  assert_commit_R3: assert property (@(posedge clk) disable iff (rst)
    commit |=> (cfg.freqWord == $past(stgFreq) && cfg.phaseOfs == $past(stgPhase)));
  // R3: without a commit the oscillator settings never move
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(cfg));
endmodule

// File: rtl/nco_phase.sv
module nco_phase
  import nco_mod_pkg::*;
#(
  parameter int ACC_BITS  = ACC_W,
  parameter int OFS_BITS  = PHOFS_W,
  parameter int ADDR_BITS = LUT_W,
  parameter int LP_BITS   = LP_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  oscCfg_t              cfg,
  input  logic                 lowPower,
  output logic [ADDR_BITS-1:0] lutAddr
);
  localparam logic [ACC_BITS-1:0]  FREQ_LP_MASK = {{LP_BITS{1'b1}}, {(ACC_BITS-LP_BITS){1'b0}}};
  localparam logic [OFS_BITS-1:0]  OFS_LP_MASK  = {{LP_BITS{1'b1}}, {(OFS_BITS-LP_BITS){1'b0}}};
  localparam logic [ADDR_BITS-1:0] ADDR_LP_MASK = {{LP_BITS{1'b1}}, {(ADDR_BITS-LP_BITS){1'b0}}};

  logic [ACC_BITS-1:0]  acc, incr;
  logic [OFS_BITS-1:0]  ofs, phSum;
  logic [ADDR_BITS-1:0] addrFull, addrNext;

  always_comb begin
    incr     = lowPower ? (cfg.freqWord & FREQ_LP_MASK) : cfg.freqWord;
    ofs      = lowPower ? (cfg.phaseOfs & OFS_LP_MASK) : cfg.phaseOfs;
    phSum    = acc[ACC_BITS-1 -: OFS_BITS] + ofs;
    addrFull = phSum[OFS_BITS-1 -: ADDR_BITS];
    addrNext = lowPower ? (addrFull & ADDR_LP_MASK) : addrFull;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      lutAddr <= '0;
    end else begin
      acc     <= acc + incr;
      lutAddr <= addrNext;
    end
  end

  // R2: a zero frequency word freezes the accumulator
  assert_freeze_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg.freqWord == '0) |=> (acc == $past(acc)));
  // R9: coarse mode leaves the low address bits clear
  assert_coarse_addr_R9: assert property (@(posedge clk) disable iff (rst)
    lowPower |=> ((lutAddr & ~ADDR_LP_MASK) == '0));
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos
  import nco_mod_pkg::*;
#(
  parameter int ADDR_BITS = LUT_W,
  parameter int AMP_BITS  = AMP_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_BITS-1:0]        lutAddr,
  output logic signed [AMP_BITS-1:0]  sinOut,
  output logic signed [AMP_BITS-1:0]  cosOut
);
  localparam int  QW       = ADDR_BITS - 2;
  localparam int  QN       = 1 << QW;
  localparam int  AMP_PEAK = (1 << (AMP_BITS-1)) - 1;
  localparam real PI_VAL   = 3.14159265358979323846;
  localparam logic signed [AMP_BITS-1:0] AMP_MIN = {1'b1, {(AMP_BITS-1){1'b0}}};

  function automatic logic signed [AMP_BITS-1:0] quarterVal(input int k);
    real ang;
    ang = 2.0 * PI_VAL * (real'(k) + 0.5) / real'(4 * QN);
    return AMP_BITS'(int'(real'(AMP_PEAK) * $sin(ang)));
  endfunction

  logic signed [AMP_BITS-1:0] romArr [QN];

  for (genvar k = 0; k < QN; k++) begin : g_rom
    localparam logic signed [AMP_BITS-1:0] ENTRY = quarterVal(k);
    assign romArr[k] = ENTRY;
  end

  logic [1:0]                 quadS, quadC;
  logic [QW-1:0]              idx;
  logic signed [AMP_BITS-1:0] magS, magC, sinNext, cosNext;

  always_comb begin
    quadS   = lutAddr[ADDR_BITS-1 -: 2];
    quadC   = quadS + 2'd1;
    idx     = lutAddr[QW-1:0];
    magS    = quadS[0] ? romArr[~idx] : romArr[idx];
    magC    = quadC[0] ? romArr[~idx] : romArr[idx];
    sinNext = quadS[1] ? -magS : magS;
    cosNext = quadC[1] ? -magC : magC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sinOut <= '0;
      cosOut <= '0;
    end else begin
      sinOut <= sinNext;
      cosOut <= cosNext;
    end
  end

  // R5: the table never produces the most negative code
  assert_amp_range_R5: assert property (@(posedge clk) disable iff (rst)
    (sinOut != AMP_MIN) && (cosOut != AMP_MIN));
endmodule

// File: rtl/nco_mixer.sv
module nco_mixer
  import nco_mod_pkg::*;
#(
  parameter int AMP_BITS  = AMP_W,
  parameter int GAIN_NUM  = 181,
  parameter int GAIN_SH   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [AMP_BITS-1:0] sampleI,
  input  logic signed [AMP_BITS-1:0] sampleQ,
  input  logic                       flip,
  input  logic                       trim,
  input  logic signed [AMP_BITS-1:0] sinVal,
  input  logic signed [AMP_BITS-1:0] cosVal,
  output logic signed [AMP_BITS-1:0] dataOut
);
  localparam int PROD_W = 2 * AMP_BITS;
  localparam int DIFF_W = PROD_W + 1;
  localparam int GAIN_W = GAIN_SH + 1;
  localparam int SCL_W  = DIFF_W + GAIN_W;
  localparam int FRAC   = AMP_BITS - 1;
  localparam logic signed [GAIN_W-1:0] GAIN_C   = GAIN_W'(GAIN_NUM);
  localparam logic signed [SCL_W-1:0]  GAIN_RND = SCL_W'(1) <<< (GAIN_SH - 1);
  localparam logic signed [SCL_W-1:0]  OUT_RND  = SCL_W'(1) <<< (FRAC - 1);
  localparam logic signed [SCL_W-1:0]  SAT_MAX  = SCL_W'((1 << FRAC) - 1);
  localparam logic signed [SCL_W-1:0]  SAT_MIN  = -SAT_MAX - SCL_W'(1);

  logic signed [AMP_BITS-1:0] iS1, qS1, iS2, qS2;
  logic                       flipS1, flipS2, trimS1, trimS2, trimS3;
  logic signed [PROD_W-1:0]   pIc, pQs;
  logic signed [DIFF_W-1:0]   diffNext, diffS3;
  logic signed [SCL_W-1:0]    wide, gained, scaled, roundedW;
  logic signed [AMP_BITS-1:0] satNext;

  always_comb begin
    pIc      = PROD_W'(iS2) * PROD_W'(cosVal);
    pQs      = PROD_W'(qS2) * PROD_W'(sinVal);
    diffNext = flipS2 ? (DIFF_W'(pIc) + DIFF_W'(pQs)) : (DIFF_W'(pIc) - DIFF_W'(pQs));
    wide     = SCL_W'(diffS3);
    gained   = wide * SCL_W'(GAIN_C);
    scaled   = trimS3 ? ((gained + GAIN_RND) >>> GAIN_SH) : wide;
    roundedW = (scaled + OUT_RND) >>> FRAC;
    if (roundedW > SAT_MAX)      satNext = SAT_MAX[AMP_BITS-1:0];
    else if (roundedW < SAT_MIN) satNext = SAT_MIN[AMP_BITS-1:0];
    else                         satNext = roundedW[AMP_BITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iS1 <= '0; qS1 <= '0; flipS1 <= 1'b0; trimS1 <= 1'b0;
      iS2 <= '0; qS2 <= '0; flipS2 <= 1'b0; trimS2 <= 1'b0;
      diffS3 <= '0; trimS3 <= 1'b0;
      dataOut <= '0;
    end else begin
      iS1 <= sampleI; qS1 <= sampleQ; flipS1 <= flip; trimS1 <= trim;
      iS2 <= iS1;     qS2 <= qS1;     flipS2 <= flipS1; trimS2 <= trimS1;
      diffS3 <= diffNext; trimS3 <= trimS2;
      dataOut <= satNext;
    end
  end

  // R6: silent baseband gives a zero mix regardless of the carrier
  assert_zero_mix_R6: assert property (@(posedge clk) disable iff (rst)
    (iS2 == '0 && qS2 == '0) |=> (diffS3 == '0));
  // R7: an overrange value lands on the positive limit
  assert_sat_high_R7: assert property (@(posedge clk) disable iff (rst)
    (roundedW > SAT_MAX) |=> (dataOut == SAT_MAX[AMP_BITS-1:0]));
  // R7: an underrange value lands on the negative limit
  assert_sat_low_R7: assert property (@(posedge clk) disable iff (rst)
    (roundedW < SAT_MIN) |=> (dataOut == SAT_MIN[AMP_BITS-1:0]));
endmodule

// File: rtl/nco_upmix.sv
module nco_upmix
  import nco_mod_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [AMP_W-1:0]  sampleI,
  input  logic signed [AMP_W-1:0]  sampleQ,
  input  logic                     flipSideband,
  input  logic                     lowPower,
  input  logic                     gainTrim,
  input  logic                     regWrEn,
  input  logic [RADDR_W-1:0]       regAddr,
  input  logic [BYTE_W-1:0]        regData,
  input  logic                     regCommit,
  output logic signed [AMP_W-1:0]  modOut
);
  oscCfg_t                 oscCfg;
  logic [LUT_W-1:0]        lutAddr;
  logic signed [AMP_W-1:0] sinVal, cosVal;

  nco_regs i_regs (
    .clk(clk), .rst(rst), .wrEn(regWrEn), .wrAddr(regAddr),
    .wrData(regData), .commit(regCommit), .cfg(oscCfg)
  );

  nco_phase i_phase (
    .clk(clk), .rst(rst), .cfg(oscCfg), .lowPower(lowPower), .lutAddr(lutAddr)
  );

  nco_sincos i_sincos (
    .clk(clk), .rst(rst), .lutAddr(lutAddr), .sinOut(sinVal), .cosOut(cosVal)
  );

  nco_mixer i_mixer (
    .clk(clk), .rst(rst), .sampleI(sampleI), .sampleQ(sampleQ),
    .flip(flipSideband), .trim(gainTrim), .sinVal(sinVal), .cosVal(cosVal),
    .dataOut(modOut)
  );
endmodule

// File: tb/test_nco_upmix.sv
module test_nco_upmix;
  localparam int CLK_PERIOD = 10;
  localparam real PI_VAL = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [13:0] sampleI = '0, sampleQ = '0;
  logic flipSideband = 1'b0, lowPower = 1'b0, gainTrim = 1'b0;
  logic regWrEn = 1'b0, regCommit = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regData = '0;
  logic signed [13:0] modOut;

  nco_upmix i_nco_upmix (
    .clk(clk), .rst(rst), .sampleI(sampleI), .sampleQ(sampleQ),
    .flipSideband(flipSideband), .lowPower(lowPower), .gainTrim(gainTrim),
    .regWrEn(regWrEn), .regAddr(regAddr), .regData(regData),
    .regCommit(regCommit), .modOut(modOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int due; int val; string tag; } item_t;
  item_t sb[$];
  int cyc = 0, total = 0, bad = 0;
  bit done = 1'b0;
  string curTag = "R1";

  bit [31:0] mAcc, mActF, mStgF;
  bit [15:0] mActP, mStgP;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int expOut(bit [31:0] acc, bit [15:0] ph, int i, int q,
                                bit flip, bit lp, bit trim);
    bit [15:0] ph16, ofs;
    int p10, c, s;
    real ang;
    longint d, y;
    ofs  = lp ? (ph & 16'hF800) : ph;
    ph16 = acc[31:16] + ofs;                       // R4
    p10  = lp ? (int'(ph16[15:11]) << 5) : int'(ph16[15:6]);  // R5, R9
    ang  = 2.0 * PI_VAL * (real'(p10) + 0.5) / 1024.0;
    c    = int'(8191.0 * $cos(ang));
    s    = int'(8191.0 * $sin(ang));
    d    = longint'(i) * c + (flip ? longint'(q) * s : -(longint'(q) * s));  // R6
    if (trim) d = (d * 181 + 128) >>> 8;           // R8
    y = (d + 4096) >>> 13;                         // R7
    if (y > 8191) y = 8191;
    if (y < -8192) y = -8192;
    return int'(y);
  endfunction

  function automatic int wrap14(int x);
    return ((x + 8192) & 16383) - 8192;
  endfunction

  // one driven cycle: call at a falling edge, returns at the next falling edge
  task automatic step(int i, int q);
    item_t it;
    sampleI = 14'(i);
    sampleQ = 14'(q);
    it.due = cyc + 4;   // R10: fourth rising edge after capture
    it.val = expOut(mAcc, mActP, i, q, flipSideband, lowPower, gainTrim);
    it.tag = curTag;
    sb.push_back(it);
    @(negedge clk);
    mAcc = mAcc + (lowPower ? (mActF & 32'hF800_0000) : mActF);
    if (regCommit) begin mActF = mStgF; mActP = mStgP; end
    if (regWrEn) begin
      case (regAddr)
        3'd0: mStgF[7:0]   = regData;
        3'd1: mStgF[15:8]  = regData;
        3'd2: mStgF[23:16] = regData;
        3'd3: mStgF[31:24] = regData;
        3'd4: mStgP[7:0]   = regData;
        3'd5: mStgP[15:8]  = regData;
        default: ;
      endcase
    end
  endtask

  task automatic burst(int n, int i0, int q0, int di, int dq);
    for (int k = 0; k < n; k++) step(wrap14(i0 + k*di), wrap14(q0 + k*dq));
  endtask

  task automatic writeReg(int a, int v);
    regWrEn = 1'b1; regAddr = 3'(a); regData = 8'(v);
    step(1200, -700);
    regWrEn = 1'b0;
  endtask

  task automatic commitRegs();
    regCommit = 1'b1;
    step(-900, 400);
    regCommit = 1'b0;
  endtask

  task automatic loadFreq(bit [31:0] f);
    for (int b = 0; b < 4; b++) writeReg(b, int'(f[b*8 +: 8]));
  endtask

  // monitor: compares results in the cycle they are due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (it.due != cyc || int'(modOut) != it.val) begin
        bad++;
        $display("FAIL %s: cycle %0d modOut=%0d expected=%0d (due %0d)",
                 it.tag, cyc, modOut, it.val, it.due);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mAcc = '0; mActF = 32'h2666_6666; mStgF = 32'h2666_6666; mActP = '0; mStgP = '0;
    // R1: output is zero while reset is held
    repeat (4) begin
      @(negedge clk);
      total++;
      if (modOut !== 14'sd0) begin
        bad++;
        $display("FAIL R1: modOut=%0d expected=0 during reset", modOut);
      end
    end
    rst = 1'b0;
    // R1, R2, R5, R10: default frequency word after reset
    curTag = "R1"; burst(4, 0, 0, 0, 0);
    curTag = "R2"; burst(40, 5000, 0, 37, 0);
    curTag = "R5"; burst(30, -6000, 2500, 211, -97);
    // R6: both sidebands
    curTag = "R6"; burst(25, 0, 3000, 0, 53);
    flipSideband = 1'b1;
    burst(25, 2000, 3000, -41, 53);
    flipSideband = 1'b0;
    // R3: staged writes leave the output on the old word until commit
    curTag = "R3";
    loadFreq(32'h0123_4567);
    writeReg(4, 8'h00); writeReg(5, 8'h40);
    burst(10, 3000, -2000, 17, 9);
    commitRegs();
    burst(30, 3000, -2000, 17, 9);
    // R4: frozen accumulator exposes the phase offset alone
    curTag = "R4";
    loadFreq(32'h0000_0000);
    commitRegs();
    burst(8, 4000, 4000, 0, 0);
    writeReg(5, 8'h20); writeReg(4, 8'h00);
    commitRegs();
    burst(8, 4000, 4000, 0, 0);
    // R10: single impulse between zeros
    curTag = "R10";
    burst(3, 0, 0, 0, 0);
    step(4000, 0);
    burst(5, 0, 0, 0, 0);
    // R7: full-scale inputs saturate
    curTag = "R7";
    loadFreq(32'h0100_0000);
    commitRegs();
    burst(40, 8191, -8192, 0, 0);
    burst(20, -8192, 8191, 0, 0);
    // R8: gain trim keeps full scale inside range
    curTag = "R8"; gainTrim = 1'b1;
    burst(40, 8191, -8192, 0, 0);
    burst(20, 6000, -3000, -300, 150);
    gainTrim = 1'b0;
    // R9: coarse oscillator mode
    curTag = "R9";
    loadFreq(32'h1234_5678);
    writeReg(4, 8'hFF); writeReg(5, 8'h3F);
    commitRegs();
    lowPower = 1'b1;
    burst(40, 5000, 2000, 13, -7);
    flipSideband = 1'b1;
    burst(20, -4000, 6000, 11, 5);
    lowPower = 1'b0; flipSideband = 1'b0;
    burst(10, 1000, 1000, 0, 0);
    // drain the scoreboard
    for (int w = 0; w < 10 && sb.size() > 0; w++) @(negedge clk);
    if (sb.size() != 0) begin
      bad++; total++;
      $display("FAIL R10: %0d results never arrived, expected=0", sb.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule